// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit buses, called port A and port B. It holds two storage banks. The forward bank carries data from A to B, and the reverse bank carries data from B to A. Each direction has three active-low controls of its own: a select, a load strobe and a drive request. While its select is low, a bank follows its source port as long as the load strobe is low. It freezes on the value present in the cycle where the strobe rises. The opposite port is driven with the bank's contents only when select and drive request are both low. For each port the block gives the input data, the output data (always the bank contents) and a drive-enable, so that a pad ring can build real tristate buffers.

All inputs are sampled on a single system clock. Each bank runs a small state machine: `LAT_IDLE` (deselected, holding), `LAT_OPEN` (transparent, loading every cycle) and `LAT_SHUT` (frozen after capture). The transitions are these:
- IDLE→OPEN on select low with strobe low.
- IDLE→SHUT on select low with strobe high, with no capture.
- OPEN→OPEN while the strobe stays low.
- OPEN→SHUT on the strobe rising, which captures that cycle's input.
- SHUT→OPEN on the strobe going low again.
- OPEN or SHUT→IDLE on select high.

A port is never driven while the bank sourced from that same port is transparent, because that would feed the block's own output back into its input. A clash flag reports cycles in which both directions request to drive.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both banks to zero and forces `a_drive`, `b_drive` and `clash` low.
- R2: In a cycle with `ab_sel_n` low and `ab_load_n` low, the forward bank loads `a_in`, and `b_out` shows that value after the next clock edge.
- R3: With `ab_sel_n` low, the cycle in which `ab_load_n` is high after a low cycle captures that cycle's `a_in`. Later values are ignored until the strobe goes low again. A strobe that is already high when the select falls captures nothing.
- R4: While `ab_sel_n` is high, the forward bank holds its value whatever the strobe does, including a strobe that rises in the same cycle as the select, and `b_drive` is low.
- R5: With `ab_oe_n` high, `b_drive` is low, but loading and capture still follow `ab_sel_n` and `ab_load_n`.
- R6: `b_drive` is high only in the cycle after `ab_sel_n` and `ab_oe_n` were both low, and `b_out` always shows the forward bank contents.
- R7: The reverse direction behaves the same way with `ba_sel_n`, `ba_load_n` and `ba_oe_n`, loading from `b_in` and driving `a_out`/`a_drive`, independently of the forward direction.
- R8: `clash` is high in the cycle after both directions requested to drive (select low and drive request low on both).
- R9: `b_drive` stays low after a cycle in which the reverse bank was transparent (`ba_sel_n` and `ba_load_n` low), and `a_drive` stays low after a cycle in which the forward bank was transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 8 | Data arriving from port A |
| a_out | output | 8 | Reverse bank contents for port A |
| a_drive | output | 1 | Port A pad drive enable |
| b_in | input | 8 | Data arriving from port B |
| b_out | output | 8 | Forward bank contents for port B |
| b_drive | output | 1 | Port B pad drive enable |
| ab_sel_n | input | 1 | Forward select, active low |
| ab_load_n | input | 1 | Forward load strobe, low = transparent |
| ab_oe_n | input | 1 | Forward drive request, active low |
| ba_sel_n | input | 1 | Reverse select, active low |
| ba_load_n | input | 1 | Reverse load strobe, low = transparent |
| ba_oe_n | input | 1 | Reverse drive request, active low |
| clash | output | 1 | Both directions requested to drive |

## Verification
Every output is a register, so an input pattern applied before clock edge k shows on the bank contents, the drive enables and the clash flag just after edge k. The bench never sees any of them two edges late. It changes inputs one time unit after a rising edge, waits for the following rising edge and samples one time unit later. In this way each table row's expected value belongs exactly to that row's inputs and to the state left by the rows before it.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        LAT_IDLE = 2'd0,
        LAT_OPEN = 2'd1,
        LAT_SHUT = 2'd2
    } lat_state_t;
endpackage

// File: rtl/xcvr_bank.sv
module xcvr_bank
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output lat_state_t   state_o
);
    lat_state_t state, nxt;
    logic       cap;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= LAT_IDLE;
        else     state <= nxt;
    end

    // next state and capture strobe
    always_comb begin
        nxt = state;
        cap = 1'b0;
        unique case (state)
            LAT_IDLE: begin
                if (!sel_n) begin
                    if (!load_n) begin
                        nxt = LAT_OPEN;
                        cap = 1'b1;
                    end else begin
                        nxt = LAT_SHUT;
                    end
                end
            end
            LAT_OPEN: begin
                if (sel_n) begin
                    nxt = LAT_IDLE;
                end else begin
                    cap = 1'b1;
                    nxt = load_n ? LAT_SHUT : LAT_OPEN;
                end
            end
            LAT_SHUT: begin
                if (sel_n) begin
                    nxt = LAT_IDLE;
                end else if (!load_n) begin
                    nxt = LAT_OPEN;
                    cap = 1'b1;
                end
            end
            default: nxt = LAT_IDLE;
        endcase
    end

    // storage
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (cap) q <= din;
    end

    assign state_o = state;
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl (
    input  logic clk,
    input  logic rst,
    input  logic ab_sel_n,
    input  logic ab_load_n,
    input  logic ab_oe_n,
    input  logic ba_sel_n,
    input  logic ba_load_n,
    input  logic ba_oe_n,
    output logic a_drive,
    output logic b_drive,
    output logic clash
);
    logic want_b, want_a, ab_clear, ba_clear;

    always_comb begin
        want_b   = !ab_sel_n && !ab_oe_n;
        want_a   = !ba_sel_n && !ba_oe_n;
        ab_clear = !(!ab_sel_n && !ab_load_n);
        ba_clear = !(!ba_sel_n && !ba_load_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_drive <= 1'b0;
            b_drive <= 1'b0;
            clash   <= 1'b0;
        end else begin
            b_drive <= want_b && ba_clear;
            a_drive <= want_a && ab_clear;
            clash   <= want_a && want_b;
        end
    end
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive,
    input  logic         ab_sel_n,
    input  logic         ab_load_n,
    input  logic         ab_oe_n,
    input  logic         ba_sel_n,
    input  logic         ba_load_n,
    input  logic         ba_oe_n,
    output logic         clash
);
    lat_state_t fwd_state, rev_state;

    xcvr_bank #(.W(W)) u_fwd (
        .clk(clk), .rst(rst), .sel_n(ab_sel_n), .load_n(ab_load_n),
        .din(a_in), .q(b_out), .state_o(fwd_state)
    );

    xcvr_bank #(.W(W)) u_rev (
        .clk(clk), .rst(rst), .sel_n(ba_sel_n), .load_n(ba_load_n),
        .din(b_in), .q(a_out), .state_o(rev_state)
    );

    xcvr_drive_ctl u_drv (
        .clk(clk), .rst(rst),
        .ab_sel_n(ab_sel_n), .ab_load_n(ab_load_n), .ab_oe_n(ab_oe_n),
        .ba_sel_n(ba_sel_n), .ba_load_n(ba_load_n), .ba_oe_n(ba_oe_n),
        .a_drive(a_drive), .b_drive(b_drive), .clash(clash)
    );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_drive,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_drive,
    input logic         ab_sel_n,
    input logic         ab_load_n,
    input logic         ab_oe_n,
    input logic         ba_sel_n,
    input logic         ba_load_n,
    input logic         ba_oe_n,
    input logic         clash
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!a_drive && !b_drive && !clash && a_out == '0 && b_out == '0)); // R1
    AST_FWD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ab_sel_n && !ab_load_n)) |-> b_out == $past(a_in)); // R2
    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ab_sel_n)) |-> (b_out == $past(b_out) && !b_drive)); // R4
    AST_B_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
        b_drive |-> $past(!ab_sel_n && !ab_oe_n)); // R6
    AST_A_DRIVE_GATED: assert property (@(posedge clk) disable iff (rst)
        a_drive |-> $past(!ba_sel_n && !ba_oe_n)); // R7
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> clash == $past(!ab_sel_n && !ab_oe_n && !ba_sel_n && !ba_oe_n)); // R8
    AST_NO_LOOP_B: assert property (@(posedge clk) disable iff (rst)
        b_drive |-> !$past(!ba_sel_n && !ba_load_n)); // R9
    AST_NO_LOOP_A: assert property (@(posedge clk) disable iff (rst)
        a_drive |-> !$past(!ab_sel_n && !ab_load_n)); // R9
endmodule

bind bidir_latch_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_sel_n(ab_sel_n), .ab_load_n(ab_load_n), .ab_oe_n(ab_oe_n),
    .ba_sel_n(ba_sel_n), .ba_load_n(ba_load_n), .ba_oe_n(ba_oe_n),
    .clash(clash)
);

// File: tb/sim_bidir_latch_xcvr.sv
module sim_bidir_latch_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] a_in, b_in, a_out, b_out;
    logic       a_drive, b_drive, clash;
    logic       ab_sel_n, ab_load_n, ab_oe_n, ba_sel_n, ba_load_n, ba_oe_n;
    int         n_chk = 0;
    int         n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_latch_xcvr u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .ab_sel_n(ab_sel_n), .ab_load_n(ab_load_n), .ab_oe_n(ab_oe_n),
        .ba_sel_n(ba_sel_n), .ba_load_n(ba_load_n), .ba_oe_n(ba_oe_n),
        .clash(clash)
    );

    // row: {ctrl[5:0] = ab sel,load,oe, ba sel,load,oe ; a_in ; b_in ;
    //       expected a_out, a_drive, b_out, b_drive, clash ; requirement}
    localparam logic [44:0] VEC [NV] = '{
        {6'b001_111, 8'h3C, 8'h11, 8'h00, 1'b0, 8'h3C, 1'b0, 1'b0, 4'd2}, // R2 transparent
        {6'b000_111, 8'h5A, 8'h11, 8'h00, 1'b0, 8'h5A, 1'b1, 1'b0, 4'd6}, // R6 drive
        {6'b010_111, 8'hA7, 8'h11, 8'h00, 1'b0, 8'hA7, 1'b1, 1'b0, 4'd3}, // R3 capture edge
        {6'b010_111, 8'hFF, 8'h11, 8'h00, 1'b0, 8'hA7, 1'b1, 1'b0, 4'd3}, // R3 frozen
        {6'b100_111, 8'h01, 8'h11, 8'h00, 1'b0, 8'hA7, 1'b0, 1'b0, 4'd4}, // R4 deselected
        {6'b110_111, 8'h02, 8'h11, 8'h00, 1'b0, 8'hA7, 1'b0, 1'b0, 4'd4}, // R4 strobe ignored
        {6'b010_111, 8'h03, 8'h11, 8'h00, 1'b0, 8'hA7, 1'b1, 1'b0, 4'd3}, // R3 no capture
        {6'b001_111, 8'h44, 8'h11, 8'h00, 1'b0, 8'h44, 1'b0, 1'b0, 4'd5}, // R5 loads undriven
        {6'b011_111, 8'h55, 8'h11, 8'h00, 1'b0, 8'h55, 1'b0, 1'b0, 4'd5}, // R5 capture undriven
        {6'b011_001, 8'h00, 8'h96, 8'h96, 1'b0, 8'h55, 1'b0, 1'b0, 4'd7}, // R7 reverse follow
        {6'b011_010, 8'h00, 8'h69, 8'h69, 1'b1, 8'h55, 1'b0, 1'b0, 4'd7}, // R7 reverse capture
        {6'b010_010, 8'h00, 8'h00, 8'h69, 1'b1, 8'h55, 1'b1, 1'b1, 4'd8}, // R8 clash
        {6'b001_010, 8'h21, 8'h00, 8'h69, 1'b0, 8'h21, 1'b0, 1'b0, 4'd9}, // R9 A blocked
        {6'b010_000, 8'h22, 8'h33, 8'h33, 1'b1, 8'h22, 1'b0, 1'b1, 4'd9}, // R9 B blocked
        {6'b111_111, 8'hEE, 8'hEE, 8'h33, 1'b0, 8'h22, 1'b0, 1'b0, 4'd4}  // R4 both hold
    };

    task automatic set_in(input logic [5:0] c, input logic [7:0] a, input logic [7:0] b);
        {ab_sel_n, ab_load_n, ab_oe_n, ba_sel_n, ba_load_n, ba_oe_n} = c;
        a_in = a;
        b_in = b;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [18:0] exp);
        logic [18:0] got;
        got = {a_out, a_drive, b_out, b_drive, clash};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        set_in(6'b000_000, 8'hC3, 8'h3C);
        tick();
        tick();
        check("R1", 19'h0);                      // R1 cleared during reset
        rst = 1'b0;
        set_in(6'b111_111, 8'hC3, 8'h3C);
        tick();
        check("R1", 19'h0);                      // R1 still clear after release

        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i][44:39], VEC[i][38:31], VEC[i][30:23]);
            tick();
            check($sformatf("R%0d", VEC[i][3:0]), VEC[i][22:4]);
        end

        // R4: select and strobe rise together from transparent: no capture
        set_in(6'b001_111, 8'h10, 8'h00);
        tick();
        check("R2", {8'h33, 1'b0, 8'h10, 1'b0, 1'b0});
        set_in(6'b111_111, 8'h20, 8'h00);
        tick();
        check("R4", {8'h33, 1'b0, 8'h10, 1'b0, 1'b0});

        // R1: reset in the middle of traffic
        rst = 1'b1;
        set_in(6'b000_010, 8'hAB, 8'hCD);
        tick();
        check("R1", 19'h0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule